// File: doc/BRIEF.md
# Programmable Down-Counter Timer with Missed-Service Watchdog

This block is a count-down timer clocked by the system clock and advanced by a single-cycle tick enable, nominally at 1 MHz. Software sees two 32-bit registers on a plain single-cycle read/write port: a control register at offset 0 that holds the start value, the run flag and the repeat flag, and a status register at offset 4. The status register shows the live count, the pending interrupt and the watchdog arm bit, and it takes the acknowledge request. On expiry the counter either reloads and keeps running (repeat mode) or stops (single mode). Expiry raises a level interrupt that stays high until software services it.

Servicing takes two steps. Software first writes the acknowledge bit in the status register and then reads the control register. A write alone does nothing to the interrupt, and so does a read alone. When the watchdog is armed, an expiry that arrives while the previous interrupt is still pending produces a one-cycle reset pulse. The reset therefore comes only after a second unserviced period, so software programs half of the timeout it wants. Writing zero to both registers stops the timer and disarms the watchdog.

Top module: `dcw_timer`

## Requirements
- R1: After synchronous reset, both registers read as zero and `irq` and `wdog_rst` are low.
- R2: A write to offset 0 loads the counter at once from data bits [CNT_W-1:0]. Bit 31 starts the counter and bit 30 selects repeat mode. Reading offset 0 returns bit 31 as the current run state, bit 30 as the repeat flag and bits [CNT_W-1:0] as the programmed start value, with all other bits zero.
- R3: While running, the count drops by one on each cycle with `tick` high. It holds its value on cycles without `tick`, and on every cycle while stopped.
- R4: Expiry happens on the tick that finds the count at zero, which is V+1 ticks after start value V is loaded. `irq` goes high on the next cycle.
- R5: On expiry in repeat mode, the counter reloads V and keeps running. On expiry in single mode, the run bit (offset 0 bit 31) clears and the count stays at zero.
- R6: Reading offset 4 returns the current count in bits [CNT_W-1:0], the pending interrupt in bit 29 and the watchdog arm bit in bit 31. Writes never change the count through this register.
- R7: The pending interrupt clears only when a write of 1 to offset 4 bit 30 is followed by a read of offset 0. A read of offset 0 with no prior acknowledge write leaves it set, and so does the acknowledge write on its own.
- R8: With offset 4 bit 31 set, each expiry that finds the interrupt still pending drives `wdog_rst` high for exactly the next cycle. With the bit clear, `wdog_rst` stays low.
- R9: Writing zero to offset 0 and then to offset 4 stops counting. After that, further expiries never pulse `wdog_rst` until the watchdog is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one cycle per time unit |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, when selected |
| bus_addr | input | ADDR_W | Byte offset (0 = control, 4 = status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| irq | output | 1 | Level interrupt, high while an expiry is unserviced |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the timer with CNT_W = 5. This puts the whole start-value range 0 to 31 within a single sweep. Every single-mode value is run to expiry, with the count read back after each tick, and a set of repeat-mode values, including the extremes, is carried across more than two periods. The short periods also make it cheap to produce a run of consecutive unserviced expiries, so the watchdog pulse, its absence when disarmed and its behaviour after the zeroing writes are all reached in a few dozen cycles.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int DATA_W    = 32;
    localparam int MAX_CNT_W = 29;

    // control register (offset 0)
    localparam int RUN_BIT   = 31;
    localparam int RPT_BIT   = 30;
    // status register (offset 4)
    localparam int ARM_BIT   = 31;
    localparam int ACK_BIT   = 30;
    localparam int PEND_BIT  = 29;

    typedef enum logic [1:0] {
        MODE_STOPPED = 2'b00,
        MODE_SINGLE  = 2'b10,
        MODE_REPEAT  = 2'b11
    } run_mode_e;

    typedef struct packed {
        logic wr_ctl;
        logic rd_ctl;
        logic wr_sts;
        logic rd_sts;
    } bus_op_t;

    function automatic bus_op_t decode_op(input logic sel, input logic wr,
                                          input logic hit_ctl, input logic hit_sts);
        bus_op_t op;
        op.wr_ctl = sel &  wr & hit_ctl;
        op.rd_ctl = sel & ~wr & hit_ctl;
        op.wr_sts = sel &  wr & hit_sts;
        op.rd_sts = sel & ~wr & hit_sts;
        return op;
    endfunction

    function automatic run_mode_e mode_of(input logic run, input logic rpt);
        if (!run)     return MODE_STOPPED;
        else if (rpt) return MODE_REPEAT;
        else          return MODE_SINGLE;
    endfunction

endpackage

// File: rtl/dcw_regs.sv
module dcw_regs
    import dcw_pkg::*;
#(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              run,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              pending,
    output bus_op_t           op,
    output logic              ld_run,
    output logic [CNT_W-1:0]  ld_val,
    output logic              rpt,
    output logic [CNT_W-1:0]  start_val,
    output logic              arm,
    output logic              ack_req,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STS = ADDR_W'(4);

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[PEND_BIT:CNT_W];

    always_comb begin
        op      = decode_op(bus_sel, bus_wr, bus_addr == OFS_CTL, bus_addr == OFS_STS);
        ld_run  = bus_wdata[RUN_BIT];
        ld_val  = bus_wdata[CNT_W-1:0];
        ack_req = op.wr_sts & bus_wdata[ACK_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt       <= 1'b0;
            start_val <= '0;
            arm       <= 1'b0;
        end else begin
            if (op.wr_ctl) begin
                rpt       <= bus_wdata[RPT_BIT];
                start_val <= bus_wdata[CNT_W-1:0];
            end
            if (op.wr_sts)
                arm <= bus_wdata[ARM_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (op.rd_ctl) begin
            bus_rdata[RUN_BIT]     = run;
            bus_rdata[RPT_BIT]     = rpt;
            bus_rdata[CNT_W-1:0]   = start_val;
        end else if (op.rd_sts) begin
            bus_rdata[ARM_BIT]     = arm;
            bus_rdata[PEND_BIT]    = pending;
            bus_rdata[CNT_W-1:0]   = cnt;
        end
    end

    assert_arm_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !op.wr_sts |=> $stable(arm));

endmodule

// File: rtl/dcw_counter.sv
module dcw_counter
    import dcw_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic             ld_run,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             rpt,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             expire
);

    run_mode_e mode;
    logic      at_zero;

    always_comb begin
        mode    = mode_of(run, rpt);
        at_zero = (cnt == '0);
        expire  = !load && (mode != MODE_STOPPED) && tick && at_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= ld_val;
            run <= ld_run;
        end else if (tick) begin
            unique case (mode)
                MODE_STOPPED: ;
                MODE_SINGLE: begin
                    if (at_zero) run <= 1'b0;
                    else         cnt <= cnt - 1'b1;
                end
                MODE_REPEAT: begin
                    if (at_zero) cnt <= start_val;
                    else         cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(ld_val)) && (run == $past(ld_run)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt) && $stable(run));

    assert_single_stop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> ($past(load) || !$past(rpt)));

endmodule

// File: rtl/dcw_irq_wdog.sv
module dcw_irq_wdog (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack_req,
    input  logic ctl_read,
    input  logic arm,
    output logic pending,
    output logic wdog_rst
);

    logic ack_armed;
    logic service;

    assign service = ack_armed & ctl_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_armed <= 1'b0;
            pending   <= 1'b0;
            wdog_rst  <= 1'b0;
        end else begin
            if (ack_req)      ack_armed <= 1'b1;
            else if (service) ack_armed <= 1'b0;

            // a fresh expiry outranks a service in the same cycle
            if (expire)       pending <= 1'b1;
            else if (service) pending <= 1'b0;

            wdog_rst <= expire & pending & arm;
        end
    end

    assert_irq_from_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(expire));

    assert_clear_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(ack_armed) && $past(ctl_read));

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> $past(pending) && $past(arm) && $past(expire));

endmodule

// File: rtl/dcw_timer.sv
module dcw_timer
    import dcw_pkg::*;
#(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);

    bus_op_t          op;
    logic             ld_run, rpt, arm, ack_req;
    logic [CNT_W-1:0] ld_val, start_val, cnt;
    logic             run, expire, pending;

    initial begin
        assert (CNT_W >= 1 && CNT_W <= MAX_CNT_W)
            else $error("CNT_W out of range");
        assert (ADDR_W >= 3)
            else $error("ADDR_W too small for offset 4");
    end

    dcw_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .run(run), .cnt(cnt), .pending(pending),
        .op(op), .ld_run(ld_run), .ld_val(ld_val), .rpt(rpt), .start_val(start_val),
        .arm(arm), .ack_req(ack_req), .bus_rdata(bus_rdata)
    );

    dcw_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick),
        .load(op.wr_ctl), .ld_run(ld_run), .ld_val(ld_val),
        .rpt(rpt), .start_val(start_val),
        .cnt(cnt), .run(run), .expire(expire)
    );

    dcw_irq_wdog u_irq (
        .clk(clk), .rst(rst), .expire(expire), .ack_req(ack_req),
        .ctl_read(op.rd_ctl), .arm(arm),
        .pending(pending), .wdog_rst(wdog_rst)
    );

    assign irq = pending;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !irq && !wdog_rst);

    assert_disarmed_silent_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(arm) |-> !wdog_rst);

endmodule

// File: tb/dcw_timer_bench.sv
module dcw_timer_bench;

    localparam int CW = 5;
    localparam int AW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdog_rst;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dcw_timer #(.CNT_W(CW), .ADDR_W(AW)) u_dcw_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdog_rst(wdog_rst)
    );

    localparam logic [31:0] RUN = 32'h8000_0000;
    localparam logic [31:0] RPT = 32'h4000_0000;
    localparam logic [31:0] ARM = 32'h8000_0000;
    localparam logic [31:0] ACK = 32'h4000_0000;
    localparam logic [31:0] PND = 32'h2000_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic service();
        logic [31:0] d;
        wr(3'd4, ACK);
        rd(3'd0, d);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] s0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); chk("R1 ctl", d, 32'h0);
        rd(3'd4, d); chk("R1 sts", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 wdog_rst", {31'h0, wdog_rst}, 32'h0);

        // single mode, every start value
        for (int v = 0; v < (1 << CW); v++) begin
            wr(3'd0, RUN | 32'(v));
            rd(3'd0, d); chk("R2 ctl readback", d, RUN | 32'(v));
            for (int k = 1; k <= v; k++) begin
                pulse_tick();
                rd(3'd4, d); chk("R3 count", d, 32'(v - k));
                chk("R4 no early irq", {31'h0, irq}, 32'h0);
            end
            pulse_tick();
            chk("R4 irq after v+1 ticks", {31'h0, irq}, 32'h1);
            rd(3'd4, d); chk("R6 sts pending", d, PND);
            pulse_tick();
            rd(3'd4, d); chk("R5 single holds zero", d, PND);
            rd(3'd0, d); chk("R5 run cleared", d, 32'(v));
            chk("R7 read alone keeps irq", {31'h0, irq}, 32'h1);
            wr(3'd4, ACK);
            chk("R7 write alone keeps irq", {31'h0, irq}, 32'h1);
            rd(3'd0, d);
            chk("R7 write+read clears", {31'h0, irq}, 32'h0);
        end

        // repeat mode, several start values across >2 periods
        foreach (s0[i]) ;
        for (int j = 0; j < 5; j++) begin
            int v;
            v = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : (j == 3) ? 5 : 31;
            wr(3'd0, RUN | RPT | 32'(v));
            for (int t = 1; t <= 2 * (v + 1) + 1; t++) begin
                pulse_tick();
                chk("R8 disarmed no pulse", {31'h0, wdog_rst}, 32'h0);
                rd(3'd4, d);
                chk("R5 repeat count", d & 32'h1f, 32'(v - (t % (v + 1))));
                chk("R4 irq level", {31'h0, irq}, (t >= v + 1) ? 32'h1 : 32'h0);
            end
            rd(3'd4, s0);
            rd(3'd4, d); chk("R3 hold without tick", d, s0);
            rd(3'd0, d); chk("R5 repeat keeps run", d, RUN | RPT | 32'(v));
            service();
            chk("R7 repeat service", {31'h0, irq}, 32'h0);
        end

        // stopped: load without run bit
        wr(3'd0, 32'd9);
        repeat (5) pulse_tick();
        rd(3'd4, d); chk("R3 stopped holds", d, 32'd9);
        chk("R3 stopped no irq", {31'h0, irq}, 32'h0);

        // watchdog
        wr(3'd4, ARM);
        rd(3'd4, d); chk("R6 arm readback", d, 32'd9 | ARM);
        wr(3'd0, RUN | RPT | 32'd2);
        repeat (3) pulse_tick();
        chk("R8 first expiry irq", {31'h0, irq}, 32'h1);
        chk("R8 first expiry no pulse", {31'h0, wdog_rst}, 32'h0);
        repeat (2) begin
            pulse_tick();
            chk("R8 mid-period no pulse", {31'h0, wdog_rst}, 32'h0);
        end
        pulse_tick();
        chk("R8 second expiry pulse", {31'h0, wdog_rst}, 32'h1);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'h0, wdog_rst}, 32'h0);
        repeat (2) pulse_tick();
        pulse_tick();
        chk("R8 third expiry pulse", {31'h0, wdog_rst}, 32'h1);
        wr(3'd4, ARM | ACK);
        rd(3'd0, d);
        chk("R7 armed service", {31'h0, irq}, 32'h0);
        repeat (3) pulse_tick();
        chk("R8 after service irq", {31'h0, irq}, 32'h1);
        chk("R8 after service no pulse", {31'h0, wdog_rst}, 32'h0);

        // zero writes stop and disarm
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0);
        rd(3'd0, d); chk("R9 ctl zero", d, 32'h0);
        rd(3'd4, d); chk("R9 sts pending only", d, PND);
        repeat (4) pulse_tick();
        rd(3'd4, d); chk("R9 stopped", d, PND);
        wr(3'd0, RUN | RPT | 32'd0);
        for (int t = 0; t < 4; t++) begin
            pulse_tick();
            chk("R9 disarmed no pulse", {31'h0, wdog_rst}, 32'h0);
        end
        chk("R9 irq still pending", {31'h0, irq}, 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule